// File: doc/BRIEF.md
# Dual-Width Arithmetic-Logic Unit with Status Flags

This block is the execution stage of a small processor datapath. It computes one of nine operations on two byte-wide operands. The operations are add, subtract, AND, OR, XOR, NOT, shift left, shift right and compare. A run-time width bit selects how wide each operation is. With the bit at 0, the operation uses all eight bits. With the bit at 1, only the low nibble takes part: the upper nibbles of the operands are ignored, the upper nibble of the result is zero, and every flag is taken at the nibble boundary.

The result path is purely combinational. It is valid in the same cycle as the opcode and operands. There is no valid/ready handshake: the block holds no data and never stalls, so it applies no back-pressure. The sequencer that drives it may change the inputs on any cycle. A result-write strobe tells the register file whether the opcode produces a value to store. Five status flags (carry, zero, sign, overflow, even parity) sit in a register. That register loads on a clock edge when the flag-write enable is high and the opcode is one of the nine operations.

Top module: `dwalu_top`

## Requirements
- R1: Opcodes are 0x02 add, 0x03 subtract, 0x04 AND, 0x05 OR, 0x06 XOR, 0x07 NOT (of the first operand), 0x0B shift left, 0x0C shift right and 0x0D compare. `res_we` is high for the first eight and low for compare and for every other code; `res_o` is 0 whenever `res_we` is low.
- R2: With `nib_mode`=1 the active width W is 4: operand bits 7:4 have no effect and `res_o[7:4]` is 0. With `nib_mode`=0, W is 8.
- R3: Add gives (A+B) mod 2^W, with carry set when A+B ≥ 2^W. Subtract gives (A−B) mod 2^W, with carry set on a borrow (A < B unsigned). Here A and B are the operands cut to W bits.
- R4: Overflow is set after add when A and B share a sign bit (bit W−1) and the result's sign differs. After subtract or compare, it is set when the signs of A and B differ and the result's sign differs from A's. All other operations clear it.
- R5: AND, OR, XOR and NOT give the bitwise result in W bits and clear carry and overflow.
- R6: Shifts move A by the count B (the second operand cut to W bits) and fill with zeros. A count of W or more gives 0. Carry holds the last bit shifted out: bit W−B of A for a left shift, or bit B−1 for a right shift, when 1 ≤ B ≤ W. Carry is 0 for a count of 0 or above W.
- R7: Zero is set when the W-bit result is 0. Sign is bit W−1 of the result. Parity is set when the W-bit result has an even number of ones.
- R8: Compare loads all five flags exactly as subtract would with the same operands, and writes no result.
- R9: Flags reset to 0. They load on a rising clock edge only when `flag_we` is 1 and the opcode is one of the nine in R1; otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_code | input | 8 | Operation code |
| opnd_a | input | 8 | First operand (destination side) |
| opnd_b | input | 8 | Second operand, or shift count |
| nib_mode | input | 1 | 1 = 4-bit operation, 0 = 8-bit operation |
| flag_we | input | 1 | Allow the flag register to load |
| res_o | output | 8 | Combinational result |
| res_we | output | 1 | Result should be written back |
| cf_o | output | 1 | Carry / borrow flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Signed overflow flag |
| pf_o | output | 1 | Even parity flag |

## Verification
In nibble mode, every opcode is swept over all 256 pairs of operand nibbles. The upper operand nibbles are filled with values that vary with the operands, so any leak of those bits into a result or flag shows up against the 4-bit reference. In byte mode, a strided grid of operands covers both sign halves, carry and borrow edges, and operands equal to zero. Dense runs of shift counts from 0 past the width separate the in-range carry bit from the zero-result region. Single directed cases show that the flags hold with `flag_we` low and with an unknown opcode. They also show that compare leaves the same flags as subtract.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;

  typedef enum logic [7:0] {
    OP_ADD = 8'h02,
    OP_SUB = 8'h03,
    OP_AND = 8'h04,
    OP_OR  = 8'h05,
    OP_XOR = 8'h06,
    OP_NOT = 8'h07,
    OP_SHL = 8'h0B,
    OP_SHR = 8'h0C,
    OP_CMP = 8'h0D
  } alu_op_e;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_SHIFT = 2'd2,
    UNIT_NONE  = 2'd3
  } alu_unit_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'd0,
    LOP_OR  = 2'd1,
    LOP_XOR = 2'd2,
    LOP_NOT = 2'd3
  } logic_op_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
  } status_t;

endpackage

// File: rtl/dwalu_decode.sv
module dwalu_decode
  import dwalu_pkg::*;
(
  input  logic [7:0] op_code,
  output logic       known,
  output logic       writes,
  output alu_unit_e  unit,
  output logic       sub_sel,
  output logic       shl_sel,
  output logic_op_e  lop
);

  always_comb begin
    known   = 1'b1;
    writes  = 1'b1;
    unit    = UNIT_NONE;
    sub_sel = 1'b0;
    shl_sel = 1'b0;
    lop     = LOP_AND;
    case (op_code)
      OP_ADD: unit = UNIT_ARITH;
      OP_SUB: begin unit = UNIT_ARITH; sub_sel = 1'b1; end
      OP_CMP: begin unit = UNIT_ARITH; sub_sel = 1'b1; writes = 1'b0; end
      OP_AND: begin unit = UNIT_LOGIC; lop = LOP_AND; end
      OP_OR:  begin unit = UNIT_LOGIC; lop = LOP_OR;  end
      OP_XOR: begin unit = UNIT_LOGIC; lop = LOP_XOR; end
      OP_NOT: begin unit = UNIT_LOGIC; lop = LOP_NOT; end
      OP_SHL: begin unit = UNIT_SHIFT; shl_sel = 1'b1; end
      OP_SHR: unit = UNIT_SHIFT;
      default: begin known = 1'b0; writes = 1'b0; end
    endcase
  end

endmodule

// File: rtl/dwalu_addsub.sv
module dwalu_addsub #(
  parameter int DW = 8,
  parameter int HW = DW / 2
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub_sel,
  input  logic          nib,
  output logic [DW-1:0] sum,
  output logic          carry,
  output logic          ovf
);

  logic [DW-1:0] b_eff;
  logic [DW:0]   wide;
  logic [HW:0]   narrow;
  logic          cout;
  logic          sa, sb, sr;

  always_comb begin
    b_eff  = sub_sel ? ~b : b;
    wide   = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, sub_sel};
    narrow = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, sub_sel};
    cout   = nib ? narrow[HW] : wide[DW];
    // subtract: carry out of A + ~B + 1 is the inverse of a borrow
    carry  = sub_sel ? ~cout : cout;
    sum    = nib ? {{(DW-HW){1'b0}}, narrow[HW-1:0]} : wide[DW-1:0];
    sa     = nib ? a[HW-1]   : a[DW-1];
    sb     = nib ? b[HW-1]   : b[DW-1];
    sr     = nib ? sum[HW-1] : sum[DW-1];
    ovf    = sub_sel ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  end

endmodule

// File: rtl/dwalu_shift.sv
module dwalu_shift #(
  parameter int DW = 8,
  parameter int HW = DW / 2
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] cnt,
  input  logic          left,
  input  logic          nib,
  output logic [DW-1:0] res,
  output logic          carry
);

  localparam logic [DW-1:0] NIB_MASK = {{(DW-HW){1'b0}}, {HW{1'b1}}};

  logic [DW:0] lt;
  logic [DW:0] rt;

  always_comb begin
    // one guard bit on the outgoing side catches the last bit shifted out
    lt = {1'b0, a} << cnt;
    rt = {a, 1'b0} >> cnt;
    if (left) begin
      res   = lt[DW-1:0] & (nib ? NIB_MASK : {DW{1'b1}});
      carry = nib ? lt[HW] : lt[DW];
    end else begin
      res   = rt[DW:1];
      carry = rt[0];
    end
  end

endmodule

// File: rtl/dwalu_flaggen.sv
module dwalu_flaggen #(
  parameter int DW = 8,
  parameter int HW = DW / 2
) (
  input  logic [DW-1:0] r,
  input  logic          nib,
  output logic          zf,
  output logic          sf,
  output logic          pf
);

  always_comb begin
    zf = (r == '0);
    sf = nib ? r[HW-1] : r[DW-1];
    pf = ~^r;
  end

endmodule

// File: rtl/dwalu_top.sv
module dwalu_top
  import dwalu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    op_code,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic          nib_mode,
  input  logic          flag_we,
  output logic [DW-1:0] res_o,
  output logic          res_we,
  output logic          cf_o,
  output logic          zf_o,
  output logic          sf_o,
  output logic          of_o,
  output logic          pf_o
);

  localparam int HW = DW / 2;
  localparam logic [DW-1:0] NIB_MASK = {{(DW-HW){1'b0}}, {HW{1'b1}}};

  logic          known, writes, sub_sel, shl_sel;
  alu_unit_e     unit;
  logic_op_e     lop;
  logic [DW-1:0] act_mask, a_m, b_m;
  logic [DW-1:0] as_res, sh_res, lg_res, calc;
  logic          as_c, as_v, sh_c;
  logic          c_nxt, v_nxt;
  logic          z_nxt, s_nxt, p_nxt;
  status_t       flags_q;

  dwalu_decode u_dec (
    .op_code (op_code),
    .known   (known),
    .writes  (writes),
    .unit    (unit),
    .sub_sel (sub_sel),
    .shl_sel (shl_sel),
    .lop     (lop)
  );

  assign act_mask = nib_mode ? NIB_MASK : {DW{1'b1}};
  assign a_m      = opnd_a & act_mask;
  assign b_m      = opnd_b & act_mask;

  dwalu_addsub #(.DW(DW), .HW(HW)) u_as (
    .a       (a_m),
    .b       (b_m),
    .sub_sel (sub_sel),
    .nib     (nib_mode),
    .sum     (as_res),
    .carry   (as_c),
    .ovf     (as_v)
  );

  dwalu_shift #(.DW(DW), .HW(HW)) u_sh (
    .a     (a_m),
    .cnt   (b_m),
    .left  (shl_sel),
    .nib   (nib_mode),
    .res   (sh_res),
    .carry (sh_c)
  );

  always_comb begin
    case (lop)
      LOP_AND: lg_res = a_m & b_m;
      LOP_OR:  lg_res = a_m | b_m;
      LOP_XOR: lg_res = a_m ^ b_m;
      default: lg_res = ~a_m & act_mask;
    endcase
  end

  always_comb begin
    case (unit)
      UNIT_ARITH: begin calc = as_res; c_nxt = as_c;  v_nxt = as_v; end
      UNIT_SHIFT: begin calc = sh_res; c_nxt = sh_c;  v_nxt = 1'b0; end
      UNIT_LOGIC: begin calc = lg_res; c_nxt = 1'b0;  v_nxt = 1'b0; end
      default:    begin calc = '0;     c_nxt = 1'b0;  v_nxt = 1'b0; end
    endcase
  end

  dwalu_flaggen #(.DW(DW), .HW(HW)) u_fg (
    .r   (calc),
    .nib (nib_mode),
    .zf  (z_nxt),
    .sf  (s_nxt),
    .pf  (p_nxt)
  );

  assign res_we = writes;
  assign res_o  = writes ? calc : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flag_we && known) begin
      flags_q <= '{cf: c_nxt, zf: z_nxt, sf: s_nxt, of: v_nxt, pf: p_nxt};
    end
  end

  assign cf_o = flags_q.cf;
  assign zf_o = flags_q.zf;
  assign sf_o = flags_q.sf;
  assign of_o = flags_q.of;
  assign pf_o = flags_q.pf;

endmodule

// File: rtl/dwalu_checker.sv
module dwalu_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    op_code,
  input logic          nib_mode,
  input logic          flag_we,
  input logic [DW-1:0] res_o,
  input logic          res_we,
  input logic          cf_o,
  input logic          zf_o,
  input logic          sf_o,
  input logic          of_o,
  input logic          pf_o
);

  localparam int HW = DW / 2;

  logic op_ok, op_logic;
  assign op_ok = (op_code == 8'h02) || (op_code == 8'h03) || (op_code == 8'h04) ||
                 (op_code == 8'h05) || (op_code == 8'h06) || (op_code == 8'h07) ||
                 (op_code == 8'h0B) || (op_code == 8'h0C) || (op_code == 8'h0D);
  assign op_logic = (op_code >= 8'h04) && (op_code <= 8'h07);

  // R1
  unknown_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ok |-> (!res_we && res_o == '0));

  // R2
  nib_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nib_mode |-> (res_o[DW-1:HW] == '0));

  // R8
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 8'h0D) |-> !res_we);

  // R5
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_logic) |=> (!cf_o && !of_o));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && res_we) |=> (zf_o == ($past(res_o) == '0)));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_we && op_ok) |=> ($stable(cf_o) && $stable(zf_o) && $stable(sf_o) &&
                             $stable(of_o) && $stable(pf_o)));

endmodule

bind dwalu_top dwalu_checker #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_code  (op_code),
  .nib_mode (nib_mode),
  .flag_we  (flag_we),
  .res_o    (res_o),
  .res_we   (res_we),
  .cf_o     (cf_o),
  .zf_o     (zf_o),
  .sf_o     (sf_o),
  .of_o     (of_o),
  .pf_o     (pf_o)
);

// File: tb/tb_dwalu_top.sv
`timescale 1ns/1ps
module tb_dwalu_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic [7:0] opnd_a = 8'h00;
  logic [7:0] opnd_b = 8'h00;
  logic       nib_mode = 1'b0;
  logic       flag_we = 1'b0;
  logic [7:0] res_o;
  logic       res_we, cf_o, zf_o, sf_o, of_o, pf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dwalu_top dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .nib_mode(nib_mode), .flag_we(flag_we), .res_o(res_o), .res_we(res_we),
    .cf_o(cf_o), .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o), .pf_o(pf_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (op %0h a %0h b %0h nib %0b)",
               req, what, act, exp, op_code, opnd_a, opnd_b, nib_mode);
    end
  endtask

  // reference: returns {we, res[7:0], cf, zf, sf, of, pf}
  function automatic logic [13:0] model(input int op, input int a, input int b, input bit nib);
    int w, m, av, bv, r, c, v, sa, sb, sr, ones, full, half;
    logic we;
    w = nib ? 4 : 8;
    m = (1 << w) - 1;
    half = 1 << (w - 1);
    av = a & m;
    bv = b & m;
    r = 0; c = 0; v = 0;
    we = 1'b1;
    sa = (av >= half) ? av - (1 << w) : av;
    sb = (bv >= half) ? bv - (1 << w) : bv;
    case (op)
      2: begin r = (av + bv) & m; c = (av + bv > m) ? 1 : 0;
               sr = sa + sb; v = (sr >= half || sr < -half) ? 1 : 0; end
      3, 13: begin r = (av - bv + (1 << w)) & m; c = (av < bv) ? 1 : 0;
               sr = sa - sb; v = (sr >= half || sr < -half) ? 1 : 0;
               if (op == 13) we = 1'b0; end
      4: r = av & bv;
      5: r = av | bv;
      6: r = av ^ bv;
      7: r = m - av;
      11: begin
            if (bv > w) begin r = 0; c = 0; end
            else begin full = av << bv; r = full & m; c = (bv == 0) ? 0 : ((full >> w) & 1); end
          end
      12: begin
            if (bv > w) begin r = 0; c = 0; end
            else begin r = av >> bv; c = (bv == 0) ? 0 : ((av >> (bv - 1)) & 1); end
          end
      default: we = 1'b0;
    endcase
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    model = {we, 8'(r), c[0], (r == 0), ((r >> (w - 1)) & 1) == 1, v[0], (ones % 2 == 0)};
  endfunction

  task automatic run_vec(input int op, input int a, input int b, input bit nib, input string req);
    logic [13:0] e;
    e = model(op, a, b, nib);
    @(negedge clk);
    op_code = 8'(op); opnd_a = 8'(a); opnd_b = 8'(b); nib_mode = nib; flag_we = 1'b1;
    #1;
    chk((op == 13) ? "R8" : "R1", "res_we", res_we, e[13]);
    chk(nib ? "R2" : req, "res", res_o, e[13] ? e[12:5] : 0);
    @(posedge clk); #1;
    chk((op == 13) ? "R8" : req, "cf", cf_o, e[4]);
    chk("R7", "zf", zf_o, e[3]);
    chk("R7", "sf", sf_o, e[2]);
    chk("R4", "of", of_o, e[1]);
    chk("R7", "pf", pf_o, e[0]);
  endtask

  function automatic string req_of(input int op);
    case (op)
      2, 3: return "R3";
      13: return "R8";
      11, 12: return "R6";
      default: return "R5";
    endcase
  endfunction

  int ops [9] = '{2, 3, 4, 5, 6, 7, 11, 12, 13};

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9", "reset flags", {cf_o, zf_o, sf_o, of_o, pf_o}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 nibble mode exhaustive with varying upper nibbles
    foreach (ops[k])
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_vec(ops[k], ((a * 5 + b * 3 + k) % 16) * 16 + a, ((b * 7 + a + 9) % 16) * 16 + b,
                  1'b1, req_of(ops[k]));

    // byte mode strided grid
    foreach (ops[k])
      for (int a = 0; a < 256; a += 7)
        for (int b = 0; b < 256; b += 13)
          run_vec(ops[k], a, b, 1'b0, req_of(ops[k]));

    // R6 dense shift counts in byte mode
    for (int s = 0; s < 12; s++) begin
      run_vec(11, 8'hA5, s, 1'b0, "R6");
      run_vec(12, 8'hA5, s, 1'b0, "R6");
      run_vec(11, 8'h81, s, 1'b0, "R6");
      run_vec(12, 8'h81, s, 1'b0, "R6");
    end

    // R3 / R4 edges
    run_vec(2, 8'hFF, 8'h01, 1'b0, "R3");
    run_vec(2, 8'h7F, 8'h01, 1'b0, "R4");
    run_vec(3, 8'h80, 8'h01, 1'b0, "R4");
    run_vec(3, 8'h00, 8'h01, 1'b0, "R3");

    // R9 flag_we low holds flags
    run_vec(2, 8'hFF, 8'h01, 1'b0, "R3");   // cf=1 zf=1 sf=0 of=0 pf=1
    @(negedge clk);
    op_code = 8'h02; opnd_a = 8'h40; opnd_b = 8'h40; nib_mode = 1'b0; flag_we = 1'b0;
    @(posedge clk); #1;
    chk("R9", "hold we=0", {cf_o, zf_o, sf_o, of_o, pf_o}, 5'b11001);

    // R9 / R1 unknown opcode with flag_we high holds flags and writes nothing
    @(negedge clk);
    op_code = 8'h0E; opnd_a = 8'h12; opnd_b = 8'h34; flag_we = 1'b1;
    #1;
    chk("R1", "unknown res_we", res_we, 0);
    chk("R1", "unknown res", res_o, 0);
    @(posedge clk); #1;
    chk("R9", "hold unknown op", {cf_o, zf_o, sf_o, of_o, pf_o}, 5'b11001);

    // R8 compare equals subtract flags
    run_vec(3, 8'h35, 8'h9C, 1'b0, "R8");
    begin
      logic [4:0] sub_f;
      sub_f = {cf_o, zf_o, sf_o, of_o, pf_o};
      run_vec(13, 8'h35, 8'h9C, 1'b0, "R8");
      chk("R8", "cmp vs sub flags", {cf_o, zf_o, sf_o, of_o, pf_o}, sub_f);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule